// File: doc/BRIEF.md
# Flash Write Completion Status Poller

This block runs on the host side of a parallel flash device. After the host has sent a program or erase command, it pulses `start` with the operation type, the target address and the byte that was written. The poller then reads that address over a simple request/acknowledge read bus until it decides whether the internal write has finished. At that point it raises either `done` or `error` for one cycle.

There are two ways to detect completion, selected when the poller is started. In data-complement mode, bit 7 of each read is compared with the expected completion value. In toggle mode, the poller waits until bit 6 stops changing between consecutive reads. A read can land at the moment the write finishes, so a single read is never trusted. Once a read looks like completion, the poller makes exactly two more reads of the same address. The write is declared complete only if both of those reads return the full expected byte. Otherwise the poller rejects the write. A polling limit set by a parameter catches a device that never finishes.

Top module: `flash_done_poller`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_req`, `done` and `error` are 0.
- R2: From the cycle after an accepted `start` until a decision, `rd_req` stays 1 and `rd_addr` holds the address captured at `start`.
- R3: In data-complement mode for a program (`op_erase`=0), a read whose bit 7 differs from bit 7 of `op_data` means the operation is still running, and polling continues.
- R4: In data-complement mode for an erase (`op_erase`=1), a read with bit 7 = 0 means the operation is still running. A read with bit 7 = 1 is a completion candidate. The target byte for an erase is 8'hFF.
- R5: In toggle mode (`use_toggle`=1), a read is a completion candidate when its bit 6 equals bit 6 of the previous accepted read of the same operation. The first read is never a candidate.
- R6: After a candidate read, the poller makes exactly two more reads. If both equal the target byte (`op_data` for a program), `done` pulses. This holds even when the candidate read itself had other bits wrong.
- R7: If either of the two confirming reads differs from the target byte, `error` pulses and `done` does not.
- R8: If MAX_POLLS accepted reads occur in the polling phase without a candidate, `error` pulses after the last of them. A candidate on read number MAX_POLLS still goes on to confirmation.
- R9: `done` and `error` are single-cycle pulses and are never high together. Each pulse appears in the cycle after the acknowledged read that decided the outcome, and `rd_req` is 0 in that same cycle.
- R10: A `start` while a poll is in progress is ignored. The address and the outcome are unchanged.
- R11: A read counts only in a cycle where `rd_req` and `rd_ack` are both 1. Wait cycles with `rd_ack`=0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (one-cycle pulse) |
| op_erase | input | 1 | 1 = erase operation, 0 = program |
| use_toggle | input | 1 | 1 = toggle-bit mode, 0 = data-complement mode |
| op_addr | input | AW | Location to poll |
| op_data | input | 8 | Byte that was programmed |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read completes this cycle |
| rd_data | input | 8 | Read data, valid with `rd_ack` |
| done | output | 1 | Write confirmed complete (pulse) |
| error | output | 1 | Write rejected or timed out (pulse) |

## Verification
The bench builds the poller with MAX_POLLS set to 6 and AW set to 18. A short limit lets the bench reach a timeout, and a candidate that lands on the very last allowed poll, in only a few reads. The 18-bit address is enough to catch a start during polling that tries to replace the address. The memory responder can run with no wait cycles or with one idle cycle between acknowledgements. This exercises both back-to-back reads and stretched reads in each detection mode.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_POLL    = 2'd1,
        ST_CONFIRM = 2'd2
    } fdp_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/fdp_read_judge.sv
module fdp_read_judge (
    input  logic [7:0] rd_data,
    input  logic [7:0] exp_data,
    input  logic       erase,
    input  logic       tmode,
    input  logic       prev6,
    input  logic       have_prev,
    output logic       cand,
    output logic       match
);
    logic [7:0] target;
    logic       bit7_fin;
    logic       tog_fin;

    always_comb begin
        target   = erase ? fdp_pkg::ERASED_BYTE : exp_data;
        bit7_fin = erase ? rd_data[7] : (rd_data[7] == exp_data[7]);
        tog_fin  = have_prev && (rd_data[6] == prev6);
        cand     = tmode ? tog_fin : bit7_fin;
        match    = (rd_data == target);
    end
endmodule

// File: rtl/fdp_poll_counter.sv
module fdp_poll_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
    parameter int AW        = 18,
    parameter int MAX_POLLS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_erase,
    input  logic          use_toggle,
    input  logic [AW-1:0] op_addr,
    input  logic [7:0]    op_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [7:0]    rd_data,
    output logic          done,
    output logic          error
);
    import fdp_pkg::*;

    typedef struct packed {
        fdp_state_e    st;
        logic          erase;
        logic          tmode;
        logic [AW-1:0] addr;
        logic [7:0]    expd;
        logic          prev6;
        logic          have;
        logic          cc;
        logic          ok;
        logic          done;
        logic          err;
    } regs_t;

    regs_t r_d, r_q;

    logic cand, match, last;
    logic take, poll_take, cnt_clr;

    fdp_read_judge u_judge (
        .rd_data  (rd_data),
        .exp_data (r_q.expd),
        .erase    (r_q.erase),
        .tmode    (r_q.tmode),
        .prev6    (r_q.prev6),
        .have_prev(r_q.have),
        .cand     (cand),
        .match    (match)
    );

    fdp_poll_counter #(.LIMIT(MAX_POLLS)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (poll_take),
        .last (last)
    );

    always_comb begin
        take      = (r_q.st != ST_IDLE) && rd_ack;
        poll_take = take && (r_q.st == ST_POLL);
        cnt_clr   = (r_q.st == ST_IDLE);

        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_POLL;
                    r_d.erase = op_erase;
                    r_d.tmode = use_toggle;
                    r_d.addr  = op_addr;
                    r_d.expd  = op_data;
                    r_d.have  = 1'b0;
                end
            end
            ST_POLL: begin
                if (take) begin
                    r_d.prev6 = rd_data[6];
                    r_d.have  = 1'b1;
                    if (cand) begin
                        r_d.st = ST_CONFIRM;
                        r_d.cc = 1'b0;
                        r_d.ok = 1'b1;
                    end else if (last) begin
                        r_d.st  = ST_IDLE;
                        r_d.err = 1'b1;
                    end
                end
            end
            ST_CONFIRM: begin
                if (take) begin
                    if (r_q.cc) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = r_q.ok && match;
                        r_d.err  = !(r_q.ok && match);
                    end else begin
                        r_d.cc = 1'b1;
                        r_d.ok = match;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req  = (r_q.st != ST_IDLE);
    assign rd_addr = r_q.addr;
    assign done    = r_q.done;
    assign error   = r_q.err;
endmodule

// File: rtl/fdp_checker.sv
module fdp_checker #(
    parameter int AW        = 18,
    parameter int MAX_POLLS = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          rd_req,
    input logic          rd_ack,
    input logic [AW-1:0] rd_addr,
    input logic          done,
    input logic          error
);
    localparam int RW = $clog2(MAX_POLLS + 3);

    logic [RW-1:0] reads_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !rd_req) reads_q <= '0;
        else if (rd_ack)       reads_q <= reads_q + 1'b1;
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_error_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);
    assert_not_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
    assert_done_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> ($past(rd_req && rd_ack) && !rd_req));
    assert_hold_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
    assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && start) |=> $stable(rd_addr));
    assert_poll_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (reads_q <= RW'(MAX_POLLS + 1)));
endmodule

bind flash_done_poller fdp_checker #(.AW(AW), .MAX_POLLS(MAX_POLLS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .rd_req (rd_req),
    .rd_ack (rd_ack),
    .rd_addr(rd_addr),
    .done   (done),
    .error  (error)
);

// File: tb/sim_flash_done_poller.sv
module sim_flash_done_poller;
    localparam int AW    = 18;
    localparam int POLLS = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_erase = 1'b0;
    logic          use_toggle = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic [7:0]    op_data = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [7:0]    rd_data = '0;
    logic          done;
    logic          error;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    flash_done_poller #(.AW(AW), .MAX_POLLS(POLLS)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
        .use_toggle(use_toggle), .op_addr(op_addr), .op_data(op_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .done(done), .error(error)
    );

    // behavioural reference model
    int            m_st = 0, m_cnt = 0, m_cc = 0;
    bit            m_have = 0, m_prev = 0, m_ok = 0, m_erase = 0, m_tog = 0;
    bit            exp_done = 0, exp_err = 0;
    logic [AW-1:0] m_addr = '0;
    logic [7:0]    m_exp = '0;

    always @(posedge clk) begin
        bit cand;
        logic [7:0] tgt;
        if (!rst_n) begin
            m_st = 0; exp_done = 0; exp_err = 0; m_addr = '0;
        end else begin
            exp_done = 0; exp_err = 0;
            if (m_st == 0) begin
                if (start) begin
                    m_st = 1; m_cnt = 0; m_have = 0;
                    m_erase = op_erase; m_tog = use_toggle;
                    m_addr = op_addr; m_exp = op_data;
                end
            end else if (rd_ack) begin
                tgt = m_erase ? 8'hFF : m_exp;
                if (m_st == 1) begin
                    if (m_tog) cand = m_have && (rd_data[6] == m_prev);
                    else if (m_erase) cand = rd_data[7];
                    else cand = (rd_data[7] == m_exp[7]);
                    m_prev = rd_data[6]; m_have = 1; m_cnt++;
                    if (cand) begin m_st = 2; m_cc = 0; m_ok = 1; end
                    else if (m_cnt >= POLLS) begin exp_err = 1; m_st = 0; end
                end else begin
                    if (rd_data != tgt) m_ok = 0;
                    m_cc++;
                    if (m_cc == 2) begin
                        if (m_ok) exp_done = 1; else exp_err = 1;
                        m_st = 0;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // responder + per-clock comparison
    logic [7:0] resp[$];
    int  gap = 0;
    bit  gap_ph = 0;
    int  reads = 0;
    int  seen_done = 0, seen_err = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(rd_req == (m_st != 0), "R2", "rd_req", rd_req, m_st != 0);
            chk(done == exp_done, "R9", "done", done, exp_done);
            chk(error == exp_err, "R9", "error", error, exp_err);
            if (m_st != 0) chk(rd_addr == m_addr, "R2", "rd_addr", rd_addr, m_addr);
            if (done) seen_done++;
            if (error) seen_err++;
        end
        if (rd_ack) reads++;
        rd_ack = 1'b0;
        if (rst_n && rd_req && resp.size() > 0) begin
            if (gap == 0 || gap_ph) begin
                rd_ack  = 1'b1;
                rd_data = resp.pop_front();
            end
            gap_ph = ~gap_ph;
        end
    end

    task automatic go(input bit er, input bit tg, input logic [AW-1:0] a,
                      input logic [7:0] d);
        @(negedge clk);
        start = 1; op_erase = er; use_toggle = tg; op_addr = a; op_data = d;
        @(negedge clk);
        start = 0;
    endtask

    task automatic finish_op(input string req, input int want_done,
                             input int want_err, input int want_reads);
        int n = 0;
        while (m_st != 0 && n < 300) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
        chk(seen_done == want_done, req, "done pulses", seen_done, want_done);
        chk(seen_err == want_err, req, "error pulses", seen_err, want_err);
        chk(reads == want_reads, req, "reads", reads, want_reads);
        seen_done = 0; seen_err = 0; reads = 0; resp.delete();
    endtask

    initial begin : wd
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!rd_req && !done && !error, "R1", "outputs in reset",
            {rd_req, done, error}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!rd_req && !done && !error, "R1", "outputs after reset",
            {rd_req, done, error}, 0);

        // R3/R6: program, complement bit7 busy then true
        resp = '{8'hDA, 8'hDA, 8'h5A, 8'h5A, 8'h5A};
        go(0, 0, 18'h1234, 8'h5A);
        finish_op("R3", 1, 0, 5);

        // R6: candidate has wrong low bits, confirms good
        resp = '{8'h50, 8'h5A, 8'h5A};
        go(0, 0, 18'h0042, 8'h5A);
        finish_op("R6", 1, 0, 3);

        // R7: second confirm read wrong
        resp = '{8'h5A, 8'h5A, 8'h12};
        go(0, 0, 18'h0100, 8'h5A);
        finish_op("R7", 0, 1, 3);

        // R4: erase
        resp = '{8'h00, 8'h7F, 8'hFF, 8'hFF, 8'hFF};
        go(1, 0, 18'h3F000, 8'h00);
        finish_op("R4", 1, 0, 5);

        // R7: erase, first confirm wrong
        resp = '{8'hFF, 8'hFE, 8'hFF};
        go(1, 0, 18'h01000, 8'h00);
        finish_op("R7", 0, 1, 3);

        // R5: toggle mode
        resp = '{8'h40, 8'h00, 8'h40, 8'h40, 8'h40, 8'h40};
        go(0, 1, 18'h00777, 8'h40);
        finish_op("R5", 1, 0, 6);

        // R8: timeout after POLLS busy reads
        resp = '{8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h00, 8'h00};
        go(0, 0, 18'h00055, 8'h00);
        finish_op("R8", 0, 1, POLLS);

        // R8: candidate on the last allowed poll still confirms
        resp = '{8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h00, 8'h00, 8'h00};
        go(0, 0, 18'h00056, 8'h00);
        finish_op("R8", 1, 0, POLLS + 2);

        // R11: wait cycles between reads
        gap = 1;
        resp = '{8'hDA, 8'hDA, 8'h5A, 8'h5A, 8'h5A};
        go(0, 0, 18'h2222, 8'h5A);
        finish_op("R11", 1, 0, 5);

        // R10: start during polling is ignored
        resp = '{8'hC0, 8'hC0, 8'hC0, 8'h33, 8'h33, 8'h33};
        go(0, 0, 18'h0ABCD, 8'h33);
        @(negedge clk);
        start = 1; op_addr = 18'h00001; op_data = 8'hC0; op_erase = 1;
        @(negedge clk);
        start = 0;
        chk(rd_addr == 18'h0ABCD, "R10", "rd_addr after busy start",
            rd_addr, 18'h0ABCD);
        finish_op("R10", 1, 0, 6);
        gap = 0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule